// File: doc/BRIEF.md
# Bus Tenure Throttle

This block sits between a bus-mastering engine and the system bus arbiter. It decides when to raise a bus request (HOLD) on the engine's behalf, how long the engine may keep the bus once the grant (HOLDA) arrives, and how long the request must stay low after the bus is given back. Two independent down-counters enforce these limits. The tenure counter caps how long the engine may act as master. The back-off counter enforces an idle gap before the next request.

Each counter has its own reload value, in clock cycles, and its own start source. With internal start, the tenure counter loads when the grant is taken and the back-off counter loads when the bus is released. With external start, a rising edge on that counter's trigger input loads it. When the tenure counter runs out, the engine is not cut off mid-transfer. The request stays up until the engine reports the end of its current transfer, and then the block releases the bus and raises a status flag. That flag shows the release was forced and not voluntary.

All inputs are synchronous to `clk`. The reset is synchronous and active high.

Top module: `bus_throttle`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bus_hold` and `throttled` are 0.
- R2: `bus_hold` rises on the clock edge after one where `eng_req` is 1, the block is idle and no back-off count is pending. If `eng_req` drops while the engine owns the bus, `bus_hold` falls on the next edge and `throttled` becomes 0.
- R3: With internal tenure start and reload N>0, a grant seen on edge G ends tenure at edge G+N. From then on, `bus_hold` stays 1 until an edge with `xfer_done` or a dropped `eng_req`. At that edge `bus_hold` falls and `throttled` becomes 1.
- R4: With internal back-off start and reload M, the release edge loads M. `bus_hold` stays 0 for the next M edges and may rise at the edge after those, for at least M+1 low cycles.
- R5: A tenure reload of 0 means the engine may keep the bus for as long as it requests it.
- R6: A back-off reload of 0 lets `bus_hold` rise on the edge right after a release.
- R7: With external tenure start (`on_ext_sel`=1), the grant clears the tenure count and no limit applies until a rising edge of `on_trig` is seen while owning. That edge loads the reload value, and tenure ends that many edges later.
- R8: With external back-off start (`off_ext_sel`=1), a release loads nothing. A rising edge of `off_trig`, in any state, loads the reload value and blocks new requests until it counts out.
- R9: If `eng_req` drops before the grant, `bus_hold` falls on the next edge with no back-off and `throttled` unchanged. `holda` without a pending request has no effect.
- R10: With internal start selected, the trigger inputs have no effect on either counter.
- R11: `throttled` keeps its value from one release until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_reload | input | CNT_W | Tenure limit in cycles, 0 = unlimited |
| off_reload | input | CNT_W | Back-off gap in cycles, 0 = none |
| on_ext_sel | input | 1 | 1: tenure counter started by `on_trig` |
| off_ext_sel | input | 1 | 1: back-off counter started by `off_trig` |
| on_trig | input | 1 | External start for the tenure counter (rising edge) |
| off_trig | input | 1 | External start for the back-off counter (rising edge) |
| eng_req | input | 1 | Engine wants the bus |
| xfer_done | input | 1 | Engine's current transfer finishes this cycle |
| holda | input | 1 | Bus grant from the arbiter |
| bus_hold | output | 1 | Bus request to the arbiter (registered) |
| throttled | output | 1 | Last release was forced by tenure expiry (registered) |

## Verification
The assertions check on every cycle that the request comes only after an engine request, and that it stays low while a back-off count is pending. They also check that `throttled` rises only together with a fall of `bus_hold`, and that it cannot change during a tenure. The exact edge on which tenure ends, the wait for the transfer-done input, the trigger-started counts, and the fact that triggers are ignored in internal mode all depend on cycle counts. Only the bench scenarios can show these. The bench compares them against its behavioural model on every clock and adds directed checks at the edges of each window.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BT_IDLE  = 2'd0,
    BT_REQ   = 2'd1,
    BT_OWN   = 2'd2,
    BT_DRAIN = 2'd3
  } bt_state_e;
endpackage

// File: rtl/bt_down_counter.sv
module bt_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec_en && cnt != '0)
      cnt <= cnt - ONE;
  end
endmodule

// File: rtl/bt_rise_detect.sv
module bt_rise_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= 1'b0;
      else     prev[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev[i];
  end
endmodule

// File: rtl/bus_throttle.sv
module bus_throttle
  import bt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] on_reload,
  input  logic [CNT_W-1:0] off_reload,
  input  logic             on_ext_sel,
  input  logic             off_ext_sel,
  input  logic             on_trig,
  input  logic             off_trig,
  input  logic             eng_req,
  input  logic             xfer_done,
  input  logic             holda,
  output logic             bus_hold,
  output logic             throttled
);
  localparam int NTRIG = 2;
  localparam int TRIG_ON = 0;
  localparam int TRIG_OFF = 1;

  bt_state_e state, state_n;
  logic [NTRIG-1:0] trig_rise;
  logic [CNT_W-1:0] on_cnt, off_cnt, on_val;
  logic on_load, on_dec, off_load;
  logic grant_evt, vol_rel, forced_rel, release_evt, on_at_one, expire_evt;
  logic off_busy;

  bt_rise_detect #(.N(NTRIG)) u_trig (
    .clk(clk), .rst(rst), .sig({off_trig, on_trig}), .rise(trig_rise)
  );

  assign off_busy    = (off_cnt != '0);
  assign on_at_one   = (on_cnt == CNT_W'(1));
  assign grant_evt   = (state == BT_REQ) && eng_req && holda;
  assign vol_rel     = (state == BT_OWN) && !eng_req;
  assign forced_rel  = (state == BT_DRAIN) && (xfer_done || !eng_req);
  assign release_evt = vol_rel || forced_rel;

  // tenure counter: grant loads (zero in external mode), trigger reloads in OWN
  assign on_load = grant_evt || (on_ext_sel && (state == BT_OWN) && trig_rise[TRIG_ON]);
  assign on_val  = (grant_evt && on_ext_sel) ? '0 : on_reload;
  assign on_dec  = (state == BT_OWN) && !on_load;
  assign expire_evt = (state == BT_OWN) && eng_req && on_dec && on_at_one;

  // back-off counter: release loads in internal mode, trigger loads in external
  assign off_load = off_ext_sel ? trig_rise[TRIG_OFF] : release_evt;

  bt_down_counter #(.W(CNT_W)) u_on_cnt (
    .clk(clk), .rst(rst), .load(on_load), .load_val(on_val),
    .dec_en(on_dec), .cnt(on_cnt)
  );

  bt_down_counter #(.W(CNT_W)) u_off_cnt (
    .clk(clk), .rst(rst), .load(off_load), .load_val(off_reload),
    .dec_en(1'b1), .cnt(off_cnt)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      BT_IDLE:  if (eng_req && !off_busy) state_n = BT_REQ;
      BT_REQ:   if (!eng_req) state_n = BT_IDLE;
                else if (holda) state_n = BT_OWN;
      BT_OWN:   if (vol_rel) state_n = BT_IDLE;
                else if (expire_evt) state_n = BT_DRAIN;
      BT_DRAIN: if (forced_rel) state_n = BT_IDLE;
      default:  state_n = BT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BT_IDLE;
      bus_hold  <= 1'b0;
      throttled <= 1'b0;
    end else begin
      state    <= state_n;
      bus_hold <= (state_n != BT_IDLE);
      if (release_evt) throttled <= forced_rel;
    end
  end
endmodule

// File: rtl/bt_checker.sv
module bt_checker (
  input logic clk,
  input logic rst,
  input logic eng_req,
  input logic bus_hold,
  input logic throttled,
  input logic off_busy
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bus_hold && !throttled));

  assert_hold_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_hold) |-> $past(eng_req));

  assert_backoff_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (!bus_hold && off_busy) |=> !bus_hold);

  assert_forced_flag_on_release_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(throttled) |-> $fell(bus_hold));

  assert_flag_steady_in_tenure_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_hold && $past(bus_hold)) |-> $stable(throttled));
endmodule

bind bus_throttle bt_checker u_chk (
  .clk(clk), .rst(rst), .eng_req(eng_req), .bus_hold(bus_hold),
  .throttled(throttled), .off_busy(off_busy)
);

// File: tb/tb_bus_throttle.sv
module tb_bus_throttle;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] on_reload = '0, off_reload = '0;
  logic on_ext_sel = 1'b0, off_ext_sel = 1'b0;
  logic on_trig = 1'b0, off_trig = 1'b0;
  logic eng_req = 1'b0, xfer_done = 1'b0, holda = 1'b0;
  logic bus_hold, throttled;
  bit   auto_g = 1'b1;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  bus_throttle #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .on_reload(on_reload), .off_reload(off_reload),
    .on_ext_sel(on_ext_sel), .off_ext_sel(off_ext_sel),
    .on_trig(on_trig), .off_trig(off_trig), .eng_req(eng_req),
    .xfer_done(xfer_done), .holda(holda),
    .bus_hold(bus_hold), .throttled(throttled)
  );

  // arbiter stand-in: grants one cycle after the request
  always @(negedge clk) if (auto_g) holda = bus_hold;

  // behavioural reference
  int ms = 0, on_left = 0, off_left = 0;
  bit pt_on = 0, pt_off = 0, m_hold = 0, m_thr = 0;
  always @(posedge clk) begin
    bit on_r, off_r, rel;
    if (rst) begin
      ms = 0; on_left = 0; off_left = 0; pt_on = 0; pt_off = 0; m_hold = 0; m_thr = 0;
    end else begin
      on_r = on_trig && !pt_on;  off_r = off_trig && !pt_off;
      pt_on = on_trig;           pt_off = off_trig;
      rel = 0;
      case (ms)
        0: if (eng_req && off_left == 0) ms = 1;
        1: if (!eng_req) ms = 0;
           else if (holda) begin ms = 2; on_left = on_ext_sel ? 0 : int'(on_reload); end
        2: if (!eng_req) begin ms = 0; rel = 1; m_thr = 0; end
           else if (on_ext_sel && on_r) on_left = int'(on_reload);
           else if (on_left == 1) begin ms = 3; on_left = 0; end
           else if (on_left > 0) on_left--;
        default: if (xfer_done || !eng_req) begin ms = 0; rel = 1; m_thr = 1; end
      endcase
      if (off_ext_sel ? off_r : rel) off_left = int'(off_reload);
      else if (off_left > 0) off_left--;
      m_hold = (ms != 0);
    end
    #2;
    n_chk++;
    if (bus_hold !== m_hold || throttled !== m_thr) begin
      n_bad++;
      $display("FAIL %s model: hold=%b thr=%b expected hold=%b thr=%b at %0t",
               cur_req, bus_hold, throttled, m_hold, m_thr, $time);
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        step(3);
        chk("R1 hold in reset", bus_hold, 1'b0);
        chk("R1 thr in reset", throttled, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 hold after reset", bus_hold, 1'b0);
        on_reload = 5; off_reload = 4;

        cur_req = "R2";
        eng_req = 1; step(1);
        chk("R2 hold raised", bus_hold, 1'b1);
        step(3); eng_req = 0; step(1);
        chk("R2 voluntary release", bus_hold, 1'b0);
        chk("R2 not throttled", throttled, 1'b0);
        step(8);

        cur_req = "R3";
        eng_req = 1; step(20);
        chk("R3 hold kept until xfer_done", bus_hold, 1'b1);
        xfer_done = 1; step(1); xfer_done = 0;
        chk("R3 released after xfer_done", bus_hold, 1'b0);
        chk("R3 throttled set", throttled, 1'b1);

        cur_req = "R4";
        step(4);
        chk("R4 still in back-off", bus_hold, 1'b0);
        step(1);
        chk("R4 hold after back-off", bus_hold, 1'b1);
        cur_req = "R11";
        step(1);
        chk("R11 flag kept during tenure", throttled, 1'b1);
        eng_req = 0; step(1);
        chk("R11 flag cleared by voluntary release", throttled, 1'b0);
        step(8);

        cur_req = "R5";
        on_reload = 0; eng_req = 1; step(40);
        chk("R5 no tenure limit", bus_hold, 1'b1);

        cur_req = "R6";
        off_reload = 0; eng_req = 0; step(1);
        chk("R6 released", bus_hold, 1'b0);
        eng_req = 1; step(1);
        chk("R6 immediate re-request", bus_hold, 1'b1);

        cur_req = "R7";
        on_ext_sel = 1; on_reload = 3; xfer_done = 1;
        eng_req = 0; step(2); eng_req = 1; step(20);
        chk("R7 no limit before trigger", bus_hold, 1'b1);
        on_trig = 1; step(1); on_trig = 0;
        step(3);
        chk("R7 tenure still running", bus_hold, 1'b1);
        step(1);
        chk("R7 released after triggered count", bus_hold, 1'b0);
        chk("R7 throttled", throttled, 1'b1);
        eng_req = 0; xfer_done = 0; on_ext_sel = 0; step(3);

        cur_req = "R8";
        off_ext_sel = 1; off_reload = 6; on_reload = 0;
        off_trig = 1; step(1); off_trig = 0; eng_req = 1;
        step(6);
        chk("R8 triggered back-off holds request", bus_hold, 1'b0);
        step(1);
        chk("R8 request after triggered back-off", bus_hold, 1'b1);
        step(3); eng_req = 0; step(1);
        chk("R8 release", bus_hold, 1'b0);
        eng_req = 1; step(1);
        chk("R8 release loads no back-off", bus_hold, 1'b1);
        eng_req = 0; step(3);

        cur_req = "R9";
        auto_g = 0; holda = 1; step(3);
        chk("R9 grant alone ignored", bus_hold, 1'b0);
        holda = 0; eng_req = 1; step(4);
        chk("R9 waiting for grant", bus_hold, 1'b1);
        eng_req = 0; step(1);
        chk("R9 abandoned request", bus_hold, 1'b0);
        chk("R9 flag unchanged", throttled, 1'b0);
        auto_g = 1; off_ext_sel = 0; step(10);

        cur_req = "R10";
        on_reload = 4; off_reload = 3; xfer_done = 1; eng_req = 1;
        step(2); on_trig = 1; off_trig = 1; step(1); on_trig = 0; off_trig = 0;
        step(3);
        chk("R10 triggers ignored, tenure running", bus_hold, 1'b1);
        step(1);
        chk("R10 internal expiry on time", bus_hold, 1'b0);
        chk("R10 throttled", throttled, 1'b1);
        eng_req = 0; xfer_done = 0; step(5);
      end
      begin
        step(20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule